// File: doc/BRIEF.md
# Voice Channel Register Decoder

This block turns bus writes into stored playback parameters for a 64-voice sample-playback engine. A write names one of two address windows (the lower window covers voices 0 to 31, the upper one voices 32 to 63) and an address inside it. Each voice owns a 128-byte slice of its window. The decoder finds the voice and the register inside that slice, unpacks the written halfword and stores the result in per-voice tables. It also produces one-cycle start and stop pulses for the voice.

The playback engine reads the tables through a registered lookup port. It presents a voice number and receives, one clock later, the decoded values for that voice: the 21-bit sample start address, the loop flag, the sample format, the loop points, the playback rate in samples per second, the remapped pan and the volume after the taper curve. The pitch word is a small float with a signed exponent, relative to 44100 Hz. It is converted to a rate when it is written, so the reader gets a plain integer.

Top module: `voice_reg_decoder`

## Requirements
- R1: The voice number is `{wr_win, wr_addr[11:7]}` (window 0 gives voices 0..31, window 1 gives voices 32..63), and the register offset is `wr_addr[6:0]`. `key_voice` reports the voice of the write that caused a pulse.
- R2: A write at offset 0x00 stores data bits 4:0 as start-address bits 20:16 and data bit 9 as the loop flag. A write at offset 0x04 stores data bits 15:0 as start-address bits 15:0 and leaves bits 20:16 unchanged.
- R3: At offset 0x00, data bits 8:7 give the format. Code 0 reads back as `rd_format` 0 (16-bit PCM), code 1 reads back as 1 (8-bit PCM), and codes 2 and 3 both read back as 2 (ADPCM).
- R4: At offset 0x00, data bits 15:14 equal to 3 raise `key_start`, and equal to 2 raise `key_stop`. Either pulse is high for exactly the one cycle after the write edge. Values 0 and 1 raise neither, and the two pulses are never high together.
- R5: Offset 0x08 stores the loop start and offset 0x0C stores the loop end, each from data bits 15:0.
- R6: Offset 0x18 holds the pitch: mantissa m in bits 9:0, exponent field f in bits 13:11, negative flag in bit 14, and bit 10 has no effect. When the flag is clear, rate = (44100<<f) + ((44100*m)>>(10-f)). When it is set, e = 8-f and rate = (44100>>e) + ((44100*m)>>(10+e)). All divisions round down.
- R7: Offset 0x24 stores a pan from data bits 4:0. Values 0..15 read back as 15 minus the value, and values 16..31 read back unchanged.
- R8: Offset 0x28 takes an index v from data bits 7:0 and stores the volume (v*v + 255) >> 8. This curve never decreases, gives 0 at v=0 and gives 255 at v=255.
- R9: Data bits 31:16 have no effect on any stored value or pulse. Writes to any offset other than 0x00, 0x04, 0x08, 0x0C, 0x18, 0x24 and 0x28 change nothing.
- R10: The read outputs show the tables for the `rd_voice` value sampled at the previous clock edge. While `rst` is high, all read outputs, `key_start`, `key_stop` and `key_voice` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_win | input | 1 | Window select: 0 for voices 0..31, 1 for voices 32..63 |
| wr_addr | input | 12 | Byte address inside the window |
| wr_data | input | 32 | Write data; only bits 15:0 are used |
| rd_voice | input | 6 | Voice to look up |
| rd_start | output | 21 | Sample start address |
| rd_loop_en | output | 1 | Loop enable |
| rd_format | output | 2 | 0 = 16-bit PCM, 1 = 8-bit PCM, 2 = ADPCM |
| rd_loop_start | output | 16 | Loop start |
| rd_loop_end | output | 16 | Loop end |
| rd_rate | output | 24 | Playback rate in samples per second |
| rd_pan | output | 5 | Remapped pan |
| rd_vol | output | 8 | Volume after the taper curve |
| key_start | output | 1 | One-cycle start pulse |
| key_stop | output | 1 | One-cycle stop pulse |
| key_voice | output | 6 | Voice of the last key command |

## Verification
A wrong voice or offset decode writes the value into another voice's entry or into another field. It shows up only when that voice is read back, one cycle after `rd_voice` is presented. The bench therefore reads every field right after writing it, and reads the neighbouring fields again after writes to ignored offsets. Errors in the pitch arithmetic or the pan and volume mapping are plain numeric mismatches on the next read; the table includes pitch words at both ends of the exponent range. A key decode error is visible on the cycle right after the write, and a pulse that lasts too long is visible one cycle after that.

// File: rtl/vrd_pkg.sv
package vrd_pkg;

  typedef enum logic [1:0] {
    FMT_PCM16 = 2'd0,
    FMT_PCM8  = 2'd1,
    FMT_ADPCM = 2'd2
  } fmt_e;

  // register offsets inside a voice slice
  localparam int OFF_CFG      = 'h00;
  localparam int OFF_START_LO = 'h04;
  localparam int OFF_LOOP_BEG = 'h08;
  localparam int OFF_LOOP_FIN = 'h0C;
  localparam int OFF_PITCH    = 'h18;
  localparam int OFF_PAN      = 'h24;
  localparam int OFF_VOL      = 'h28;

  typedef struct packed {
    logic cfg;
    logic start_lo;
    logic loop_beg;
    logic loop_fin;
    logic pitch;
    logic pan;
    logic vol;
  } wsel_t;

  function automatic fmt_e fmt_decode(input logic [1:0] code);
    case (code)
      2'd0:    return FMT_PCM16;
      2'd1:    return FMT_PCM8;
      default: return FMT_ADPCM;
    endcase
  endfunction

  // lower half of the range is mirrored, upper half passes through
  function automatic logic [4:0] pan_remap(input logic [4:0] v);
    return v[4] ? v : (5'd15 - v);
  endfunction

  // power taper: 0 at the bottom, full scale at the top
  function automatic int vol_curve(input int i, input int bits);
    return (i * i + ((1 << bits) - 1)) >> bits;
  endfunction

endpackage

// File: rtl/vrd_addr_split.sv
module vrd_addr_split
  import vrd_pkg::*;
#(
  parameter int WIN_W       = 1,
  parameter int ADDR_W      = 12,
  parameter int STRIDE_BITS = 7,
  localparam int VOICE_W    = WIN_W + ADDR_W - STRIDE_BITS
) (
  input  logic               wr_en,
  input  logic [WIN_W-1:0]   wr_win,
  input  logic [ADDR_W-1:0]  wr_addr,
  output logic [VOICE_W-1:0] voice,
  output wsel_t              sel
);

  logic [STRIDE_BITS-1:0] off;

  assign voice = {wr_win, wr_addr[ADDR_W-1:STRIDE_BITS]};
  assign off   = wr_addr[STRIDE_BITS-1:0];

  always_comb begin
    sel = '0;
    if (wr_en) begin
      case (off)
        STRIDE_BITS'(OFF_CFG):      sel.cfg      = 1'b1;
        STRIDE_BITS'(OFF_START_LO): sel.start_lo = 1'b1;
        STRIDE_BITS'(OFF_LOOP_BEG): sel.loop_beg = 1'b1;
        STRIDE_BITS'(OFF_LOOP_FIN): sel.loop_fin = 1'b1;
        STRIDE_BITS'(OFF_PITCH):    sel.pitch    = 1'b1;
        STRIDE_BITS'(OFF_PAN):      sel.pan      = 1'b1;
        STRIDE_BITS'(OFF_VOL):      sel.vol      = 1'b1;
        default:                    sel          = '0;
      endcase
    end
  end

endmodule

// File: rtl/vrd_pitch_rate.sv
module vrd_pitch_rate #(
  parameter int BASE_RATE = 44100,
  parameter int MANT_W    = 10,
  parameter int EXP_W     = 3,
  parameter int RATE_W    = 24,
  localparam int PW       = RATE_W + MANT_W + 8
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  expf,
  input  logic              neg,
  output logic [RATE_W-1:0] rate
);

  logic [PW-1:0] base_w;
  logic [PW-1:0] prod;
  logic [PW-1:0] whole;
  logic [PW-1:0] rate_w;
  int            neg_e;

  assign base_w = PW'(BASE_RATE);
  assign prod   = base_w * PW'(mant);
  assign neg_e  = (1 << EXP_W) - int'(expf);

  always_comb begin
    if (!neg) begin
      whole  = base_w << expf;
      rate_w = whole + (prod >> (MANT_W - int'(expf)));
    end else begin
      whole  = base_w >> neg_e;
      rate_w = whole + (prod >> (MANT_W + neg_e));
    end
  end

  assign rate = RATE_W'(rate_w);

  // the result stays inside one octave above the scaled base
  always_comb begin
    if (!neg) begin
      assert_rate_band_pos_R6: assert (rate_w >= (base_w << expf) &&
                                       rate_w <  (base_w << (int'(expf) + 1)))
        else $error("positive-exponent rate outside its octave");
    end else begin
      assert_rate_band_neg_R6: assert (rate_w >= (base_w >> neg_e) &&
                                       rate_w <= ((base_w >> neg_e) << 1))
        else $error("negative-exponent rate outside its octave");
    end
  end

endmodule

// File: rtl/vrd_vol_taper.sv
module vrd_vol_taper
  import vrd_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int OUT_W = 8,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] idx,
  output logic [OUT_W-1:0] level
);

  logic [OUT_W-1:0] tbl [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    assign tbl[g] = OUT_W'(vol_curve(g, IDX_W));
  end

  assign level = tbl[idx];

  // the taper never lifts a level above its index
  always_comb begin
    assert_vol_below_index_R8: assert (int'(level) <= int'(idx))
      else $error("taper output exceeds index");
  end

endmodule

// File: rtl/voice_reg_decoder.sv
module voice_reg_decoder
  import vrd_pkg::*;
#(
  parameter int VOICES_PER_WIN = 32,
  parameter int NUM_WIN        = 2,
  parameter int STRIDE_BITS    = 7,
  parameter int DATA_W         = 32,
  parameter int WORD_W         = 16,
  parameter int START_HI_W     = 5,
  parameter int RATE_W         = 24,
  parameter int BASE_RATE      = 44100,
  parameter int VOL_W          = 8,
  parameter int PAN_W          = 5,
  localparam int WIN_W   = $clog2(NUM_WIN),
  localparam int ADDR_W  = $clog2(VOICES_PER_WIN) + STRIDE_BITS,
  localparam int NV      = VOICES_PER_WIN * NUM_WIN,
  localparam int VOICE_W = $clog2(NV),
  localparam int START_W = START_HI_W + WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WIN_W-1:0]   wr_win,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [VOICE_W-1:0] rd_voice,
  output logic [START_W-1:0] rd_start,
  output logic               rd_loop_en,
  output logic [1:0]         rd_format,
  output logic [WORD_W-1:0]  rd_loop_start,
  output logic [WORD_W-1:0]  rd_loop_end,
  output logic [RATE_W-1:0]  rd_rate,
  output logic [PAN_W-1:0]   rd_pan,
  output logic [VOL_W-1:0]   rd_vol,
  output logic               key_start,
  output logic               key_stop,
  output logic [VOICE_W-1:0] key_voice
);

  localparam int CFG_W = START_HI_W + 3;

  logic [WORD_W-1:0]  wd;
  logic               unused_hi;
  logic [VOICE_W-1:0] wv;
  wsel_t              sel;
  logic [CFG_W-1:0]   cfg_word;
  logic [RATE_W-1:0]  rate_new;
  logic [VOL_W-1:0]   vol_new;

  assign wd        = wr_data[WORD_W-1:0];
  assign unused_hi = ^wr_data[DATA_W-1:WORD_W];
  assign cfg_word  = {wd[START_HI_W-1:0], wd[9], fmt_decode(wd[8:7])};

  vrd_addr_split #(
    .WIN_W      (WIN_W),
    .ADDR_W     (ADDR_W),
    .STRIDE_BITS(STRIDE_BITS)
  ) i_split (
    .wr_en  (wr_en),
    .wr_win (wr_win),
    .wr_addr(wr_addr),
    .voice  (wv),
    .sel    (sel)
  );

  vrd_pitch_rate #(
    .BASE_RATE(BASE_RATE),
    .MANT_W   (10),
    .EXP_W    (3),
    .RATE_W   (RATE_W)
  ) i_pitch (
    .mant(wd[9:0]),
    .expf(wd[13:11]),
    .neg (wd[14]),
    .rate(rate_new)
  );

  vrd_vol_taper #(
    .IDX_W(VOL_W),
    .OUT_W(VOL_W)
  ) i_taper (
    .idx  (wd[VOL_W-1:0]),
    .level(vol_new)
  );

  // per-voice tables: one write port, one registered read port each
  logic [CFG_W-1:0]  cfg_mem  [NV];
  logic [WORD_W-1:0] slo_mem  [NV];
  logic [WORD_W-1:0] lbeg_mem [NV];
  logic [WORD_W-1:0] lfin_mem [NV];
  logic [RATE_W-1:0] rate_mem [NV];
  logic [PAN_W-1:0]  pan_mem  [NV];
  logic [VOL_W-1:0]  vol_mem  [NV];

  always_ff @(posedge clk) begin
    if (sel.cfg)      cfg_mem[wv]  <= cfg_word;
    if (sel.start_lo) slo_mem[wv]  <= wd;
    if (sel.loop_beg) lbeg_mem[wv] <= wd;
    if (sel.loop_fin) lfin_mem[wv] <= wd;
    if (sel.pitch)    rate_mem[wv] <= rate_new;
    if (sel.pan)      pan_mem[wv]  <= pan_remap(wd[PAN_W-1:0]);
    if (sel.vol)      vol_mem[wv]  <= vol_new;
  end

  logic [CFG_W-1:0]  cfg_q;
  logic [WORD_W-1:0] slo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q         <= '0;
      slo_q         <= '0;
      rd_loop_start <= '0;
      rd_loop_end   <= '0;
      rd_rate       <= '0;
      rd_pan        <= '0;
      rd_vol        <= '0;
    end else begin
      cfg_q         <= cfg_mem[rd_voice];
      slo_q         <= slo_mem[rd_voice];
      rd_loop_start <= lbeg_mem[rd_voice];
      rd_loop_end   <= lfin_mem[rd_voice];
      rd_rate       <= rate_mem[rd_voice];
      rd_pan        <= pan_mem[rd_voice];
      rd_vol        <= vol_mem[rd_voice];
    end
  end

  assign rd_start   = {cfg_q[CFG_W-1:3], slo_q};
  assign rd_loop_en = cfg_q[2];
  assign rd_format  = cfg_q[1:0];

  // key command pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      key_start <= 1'b0;
      key_stop  <= 1'b0;
      key_voice <= '0;
    end else begin
      key_start <= sel.cfg && (wd[15:14] == 2'b11);
      key_stop  <= sel.cfg && (wd[15:14] == 2'b10);
      if (sel.cfg) key_voice <= wv;
    end
  end

  assert_key_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(key_start && key_stop))
    else $error("start and stop pulses together");

  assert_key_follows_write_R4: assert property (@(posedge clk) disable iff (rst)
    (key_start || key_stop) |-> $past(wr_en))
    else $error("key pulse without a preceding write");

  assert_no_key_without_cmd_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_data[15]) |=> (!key_start && !key_stop))
    else $error("key pulse from a write with bit 15 clear");

  assert_key_voice_R1: assert property (@(posedge clk) disable iff (rst)
    (key_start || key_stop) |-> (key_voice == $past({wr_win, wr_addr[ADDR_W-1:STRIDE_BITS]})))
    else $error("key voice does not match the write address");

endmodule

// File: tb/test_voice_reg_decoder.sv
module test_voice_reg_decoder;

  localparam int K_START = 0, K_LOOP = 1, K_FMT = 2, K_LBEG = 3,
                 K_LFIN = 4, K_RATE = 5, K_PAN = 6, K_VOL = 7;

  typedef struct packed {
    logic        win;
    logic [11:0] addr;
    logic [31:0] data;
    logic [3:0]  kind;
    logic [23:0] exp;
  } vec_t;

  localparam int NVEC = 29;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 12'h000, 32'h0000_0215, 4'(K_LOOP),  24'd1},
    '{1'b0, 12'h004, 32'hFFFF_ABCD, 4'(K_START), 24'h15ABCD},
    '{1'b0, 12'h000, 32'h0000_0080, 4'(K_FMT),   24'd1},
    '{1'b0, 12'h004, 32'h0000_1234, 4'(K_START), 24'h001234},
    '{1'b1, 12'hF80, 32'h0000_011F, 4'(K_FMT),   24'd2},
    '{1'b1, 12'hF84, 32'h0000_0001, 4'(K_START), 24'h1F0001},
    '{1'b1, 12'hF80, 32'h0000_0180, 4'(K_FMT),   24'd2},
    '{1'b0, 12'h088, 32'h1234_5678, 4'(K_LBEG),  24'h5678},
    '{1'b1, 12'h08C, 32'h0000_BEEF, 4'(K_LFIN),  24'hBEEF},
    '{1'b0, 12'h118, 32'h0000_0000, 4'(K_RATE),  24'd44100},
    '{1'b0, 12'h118, 32'h0000_0200, 4'(K_RATE),  24'd66150},
    '{1'b0, 12'h118, 32'h0000_0800, 4'(K_RATE),  24'd88200},
    '{1'b0, 12'h118, 32'h0000_3BFF, 4'(K_RATE),  24'd11284087},
    '{1'b0, 12'h118, 32'h0000_7800, 4'(K_RATE),  24'd22050},
    '{1'b0, 12'h118, 32'h0000_43FF, 4'(K_RATE),  24'd344},
    '{1'b0, 12'h118, 32'h0000_6100, 4'(K_RATE),  24'd3445},
    '{1'b0, 12'h118, 32'h0000_0600, 4'(K_RATE),  24'd66150},
    '{1'b0, 12'h1A4, 32'h0000_0000, 4'(K_PAN),   24'd15},
    '{1'b0, 12'h1A4, 32'h0000_000F, 4'(K_PAN),   24'd0},
    '{1'b0, 12'h1A4, 32'h0000_0005, 4'(K_PAN),   24'd10},
    '{1'b0, 12'h1A4, 32'h0000_0010, 4'(K_PAN),   24'd16},
    '{1'b0, 12'h1A4, 32'h0000_001F, 4'(K_PAN),   24'd31},
    '{1'b0, 12'h1A4, 32'h0000_FFE7, 4'(K_PAN),   24'd8},
    '{1'b0, 12'h228, 32'h0000_0000, 4'(K_VOL),   24'd0},
    '{1'b0, 12'h228, 32'h0000_00FF, 4'(K_VOL),   24'd255},
    '{1'b0, 12'h228, 32'h0000_0010, 4'(K_VOL),   24'd1},
    '{1'b0, 12'h228, 32'h0000_0080, 4'(K_VOL),   24'd64},
    '{1'b0, 12'h228, 32'h0000_00C8, 4'(K_VOL),   24'd157}
    ,'{1'b0, 12'h228, 32'h0000_AB01, 4'(K_VOL),  24'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_win = 1'b0;
  logic [11:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_voice = '0;
  logic [20:0] rd_start;
  logic        rd_loop_en;
  logic [1:0]  rd_format;
  logic [15:0] rd_loop_start, rd_loop_end;
  logic [23:0] rd_rate;
  logic [4:0]  rd_pan;
  logic [7:0]  rd_vol;
  logic        key_start, key_stop;
  logic [5:0]  key_voice;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  voice_reg_decoder i_voice_reg_decoder (
    .clk, .rst, .wr_en, .wr_win, .wr_addr, .wr_data, .rd_voice,
    .rd_start, .rd_loop_en, .rd_format, .rd_loop_start, .rd_loop_end,
    .rd_rate, .rd_pan, .rd_vol, .key_start, .key_stop, .key_voice
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_win = w; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // called at a falling edge; results valid at the next falling edge
  task automatic do_read(input logic [5:0] v);
    rd_voice = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] field(input int k);
    case (k)
      K_START: return 32'(rd_start);
      K_LOOP:  return 32'(rd_loop_en);
      K_FMT:   return 32'(rd_format);
      K_LBEG:  return 32'(rd_loop_start);
      K_LFIN:  return 32'(rd_loop_end);
      K_RATE:  return 32'(rd_rate);
      K_PAN:   return 32'(rd_pan);
      default: return 32'(rd_vol);
    endcase
  endfunction

  function automatic string tag(input int k);
    case (k)
      K_START, K_LOOP: return "R2";
      K_FMT:           return "R3";
      K_LBEG, K_LFIN:  return "R5";
      K_RATE:          return "R6";
      K_PAN:           return "R7";
      default:         return "R8";
    endcase
  endfunction

  function automatic logic [5:0] voice_of(input logic w, input logic [11:0] a);
    return {w, a[11:7]};
  endfunction

  task automatic check_keys(input string req, input logic s, input logic p);
    check(req, 32'(key_start), 32'(s));
    check(req, 32'(key_stop), 32'(p));
  endtask

  initial begin : main
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", 32'(rd_start), 0);
    check("R10", 32'(rd_rate), 0);
    check("R10", 32'(rd_vol), 0);
    check_keys("R10", 1'b0, 1'b0);
    check("R10", 32'(key_voice), 0);
    rst = 1'b0;
    @(negedge clk);

    // table walk: write, then read the voice back one cycle later (R1, R10)
    for (int i = 0; i < NVEC; i++) begin
      do_write(VECS[i].win, VECS[i].addr, VECS[i].data);
      do_read(voice_of(VECS[i].win, VECS[i].addr));
      check(tag(int'(VECS[i].kind)), field(int'(VECS[i].kind)), 32'(VECS[i].exp));
    end

    // R4: start pulse on voice 40, one cycle wide
    do_write(1'b1, 12'h400, 32'h0000_C000);
    check_keys("R4", 1'b1, 1'b0);
    check("R1", 32'(key_voice), 40);
    @(negedge clk);
    check_keys("R4", 1'b0, 1'b0);

    // R4: stop pulse on voice 7
    do_write(1'b0, 12'h380, 32'h0000_8000);
    check_keys("R4", 1'b0, 1'b1);
    check("R1", 32'(key_voice), 7);
    @(negedge clk);
    check_keys("R4", 1'b0, 1'b0);

    // R4: commands 1 and 0 raise nothing
    do_write(1'b0, 12'h380, 32'h0000_4000);
    check_keys("R4", 1'b0, 1'b0);
    do_write(1'b0, 12'h380, 32'h0000_0000);
    check_keys("R4", 1'b0, 1'b0);

    // R9: upper data bits carry no key command and no field change
    do_write(1'b0, 12'h000, 32'hFFFF_0080);
    check_keys("R9", 1'b0, 1'b0);
    do_read(6'd0);
    check("R9", 32'(rd_start), 32'h001234);
    check("R9", 32'(rd_format), 1);
    check("R9", 32'(rd_loop_en), 0);

    // R9: unused offsets on voice 0 and voice 2 change nothing
    foreach (VECS[i]) begin end
    do_write(1'b0, 12'h010, 32'h0000_FFFF);
    do_write(1'b0, 12'h014, 32'h0000_FFFF);
    do_write(1'b0, 12'h01C, 32'h0000_FFFF);
    do_write(1'b0, 12'h020, 32'h0000_FFFF);
    do_write(1'b0, 12'h07C, 32'h0000_FFFF);
    check_keys("R9", 1'b0, 1'b0);
    do_write(1'b0, 12'h110, 32'h0000_FFFF);
    do_write(1'b0, 12'h119, 32'h0000_FFFF);
    do_write(1'b0, 12'h17C, 32'h0000_FFFF);
    do_read(6'd0);
    check("R9", 32'(rd_start), 32'h001234);
    check("R9", 32'(rd_format), 1);
    check("R9", 32'(rd_loop_en), 0);
    do_read(6'd2);
    check("R9", 32'(rd_rate), 66150);

    // R10: read latency, switch voice and see the new voice next cycle
    do_read(6'd63);
    check("R10", 32'(rd_start), 32'h000001);
    do_read(6'd33);
    check("R10", 32'(rd_loop_end), 32'hBEEF);

    // R10: reset clears the read registers and pulses
    rst = 1'b1;
    @(negedge clk);
    check("R10", 32'(rd_loop_end), 0);
    check("R10", 32'(key_voice), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule